// File: doc/BRIEF.md
# Peripheral Clock-Enable Controller

This block produces one clock-enable strobe per peripheral, for up to 64 peripherals, all derived from a single master clock. Each strobe is one master cycle wide. For each peripheral, software picks a power-of-two division (1, 2, 4 or 8) and can switch the strobe on or off. Downstream logic uses a strobe to qualify its flops, or to drive a gating cell outside this block.

Software reaches every peripheral through one 32-bit control word, using a select-then-access scheme:

- A write with the command flag clear only chooses the peripheral that a later read will report.
- A write with the flag set also stores that peripheral's division code and enable.
- A read returns the selected peripheral's stored settings one cycle after the request.

The two lowest peripheral numbers are pinned on. They cannot be reconfigured.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: The control word carries the peripheral number in bits 5:0. A write with bit 12 clear changes only the selection; every stored setting and every strobe is left as it was, whatever the other bits hold.
- R2: A write with bit 12 set selects the peripheral in bits 5:0 and stores the division code from bits 17:16 and the enable from bit 28 for that peripheral.
- R3: A read request returns, in the cycle after it, the selected number in bits 5:0, the stored code in bits 17:16 and the enable in bit 28, with all other bits zero. A write in the same cycle as the read does not affect what that read reports.
- R4: Peripherals 0 and 1 strobe on every master cycle. Command writes to them are ignored, and reads of them report enable 1 and code 0.
- R5: After reset, the selection is 0, the read data is 0, and every peripheral from 2 upward is disabled with code 0 and its strobe low.
- R6: An enabled peripheral with code c strobes once every 2^c master cycles. Code 0 means it strobes continuously. After an enabling write, the first strobe comes 2^c cycles after the write's clock edge.
- R7: The strobe is low from the cycle after a write that clears the enable. It stays low while the peripheral is disabled.
- R8: A code change written while a peripheral is enabled takes effect only after that peripheral's next strobe. The running interval finishes at the old period, and every later interval uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Status of the selected peripheral, valid the cycle after rd_en |
| clk_en_out | output | NUM_PERIPH | One clock-enable strobe per peripheral |

## Verification
The hardest case to reach is a code change that lands in the middle of a running interval. Catching it needs a strobe pattern that looks different depending on whether the new period applies at once or only after the pending strobe. The stimulus first starts slow dividers and lets them run. It then rewrites their codes partway through a period, in both the faster and the slower direction, and follows each change with long idle runs. A later phase issues a long stream of mixed writes and reads to arbitrary peripheral numbers, some of them arriving in the same cycle. It checks every strobe against a countdown model on every clock.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int WORD_W   = 32;
  localparam int ID_W     = 6;
  localparam int ID_LSB   = 0;
  localparam int CMD_BIT  = 12;
  localparam int DIV_W    = 2;
  localparam int DIV_LSB  = 16;
  localparam int EN_BIT   = 28;
  localparam int MAX_SHIFT = (1 << DIV_W) - 1;
  localparam int CNT_W    = MAX_SHIFT;

  typedef logic [DIV_W-1:0] div_code_t;
  typedef logic [CNT_W-1:0] div_cnt_t;

  function automatic logic [ID_W-1:0] f_id(input logic [WORD_W-1:0] w);
    return w[ID_LSB +: ID_W];
  endfunction

  function automatic logic f_is_cmd(input logic [WORD_W-1:0] w);
    return w[CMD_BIT];
  endfunction

  function automatic div_code_t f_code(input logic [WORD_W-1:0] w);
    return w[DIV_LSB +: DIV_W];
  endfunction

  function automatic logic f_en(input logic [WORD_W-1:0] w);
    return w[EN_BIT];
  endfunction

  // Final count value of a period of 2^code cycles.
  function automatic div_cnt_t f_last(input div_code_t code);
    return div_cnt_t'((32'd1 << code) - 32'd1);
  endfunction

  function automatic logic [WORD_W-1:0] f_pack(input logic [ID_W-1:0] id,
                                               input logic en,
                                               input div_code_t code);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ID_LSB +: ID_W]   = id;
    w[DIV_LSB +: DIV_W] = code;
    w[EN_BIT]           = en;
    return w;
  endfunction
endpackage

// File: rtl/pcg_regfile.sv
module pcg_regfile
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int ALWAYS_ON  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        rd_en,
  output logic [WORD_W-1:0]           rd_data,
  output logic [NUM_PERIPH-1:0]       en_vec,
  output logic [NUM_PERIPH-1:0][DIV_W-1:0] code_vec
);
  logic [ID_W-1:0]       wr_id;
  logic                  wr_cmd;
  logic                  wr_en_bit;
  div_code_t             wr_code;
  logic [NUM_PERIPH-1:0] wr_hit;
  logic [ID_W-1:0]       sel_q;
  logic                  sel_en;
  div_code_t             sel_code;
  logic                  unused_wr_bits;

  assign wr_id     = f_id(wr_data);
  assign wr_cmd    = f_is_cmd(wr_data);
  assign wr_en_bit = f_en(wr_data);
  assign wr_code   = f_code(wr_data);
  assign unused_wr_bits = ^{wr_data[31:29], wr_data[27:18], wr_data[15:13], wr_data[11:6]};

  always_comb begin
    for (int i = 0; i < NUM_PERIPH; i++) begin
      wr_hit[i] = wr_en && wr_cmd && (wr_id == ID_W'(i)) && (i >= ALWAYS_ON);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_id;
  end

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_slot
    if (g < ALWAYS_ON) begin : g_pinned
      assign en_vec[g]   = 1'b1;
      assign code_vec[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_vec[g]   <= 1'b0;
          code_vec[g] <= '0;
        end else if (wr_hit[g]) begin
          en_vec[g]   <= wr_en_bit;
          code_vec[g] <= wr_code;
        end
      end
    end
  end

  assign sel_en   = (int'(sel_q) < NUM_PERIPH) ? en_vec[sel_q] : 1'b0;
  assign sel_code = (int'(sel_q) < NUM_PERIPH) ? code_vec[sel_q] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= f_pack(sel_q, sel_en, sel_code);
  end

  // R1: a select-only write leaves every stored setting untouched
  a_r1_select_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_cmd) |=> ($stable(en_vec) && $stable(code_vec)));

  // R2: a command write to a configurable slot lands in that slot
  a_r2_cmd_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd && int'(wr_id) >= ALWAYS_ON && int'(wr_id) < NUM_PERIPH)
      |=> (en_vec[$past(wr_id)] == $past(wr_en_bit)));

  // R3: read data carries the selection that was current at the request
  a_r3_rd_id: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[ID_LSB +: ID_W] == $past(sel_q)));

  // R4: pinned slots read as enabled with code 0
  a_r4_pinned_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(sel_q) < ALWAYS_ON) |=> (rd_data[EN_BIT] && rd_data[DIV_LSB +: DIV_W] == '0));
endmodule

// File: rtl/pcg_divider.sv
module pcg_divider
  import pcg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  div_code_t req_code,
  output logic      strobe
);
  div_cnt_t  cnt_q;
  div_code_t cur_q;
  logic      run_q;
  div_code_t eff_code;
  div_cnt_t  last_cnt;
  logic      at_boundary;

  // While idle the requested code governs; once running, the latched one.
  assign eff_code    = run_q ? cur_q : req_code;
  assign last_cnt    = f_last(eff_code);
  assign at_boundary = (cnt_q == last_cnt);
  assign strobe      = en && at_boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= '0;
      run_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      cur_q <= req_code;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (at_boundary) begin
        cnt_q <= '0;
        cur_q <= req_code;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (!run_q) cur_q <= req_code;
      end
    end
  end

  // R6: the running count never passes the end of its period
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= last_cnt));

  // R8: the latched code only moves at a strobe boundary while running
  a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run_q && !strobe) |=> $stable(cur_q));

  // R7: a disabled divider starts from a cleared count
  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && !run_q));
endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pcg_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int ALWAYS_ON  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  input  logic                  rd_en,
  output logic [31:0]           rd_data,
  output logic [NUM_PERIPH-1:0] clk_en_out
);
  logic [NUM_PERIPH-1:0]            en_vec;
  logic [NUM_PERIPH-1:0][DIV_W-1:0] code_vec;

  pcg_regfile #(.NUM_PERIPH(NUM_PERIPH), .ALWAYS_ON(ALWAYS_ON)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .en_vec   (en_vec),
    .code_vec (code_vec)
  );

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_div
    pcg_divider u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_vec[g]),
      .req_code (code_vec[g]),
      .strobe   (clk_en_out[g])
    );
  end

  // R7: a disabled slot never strobes
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_out & ~en_vec) == '0);
endmodule

// File: tb/pclk_gate_ctrl_test.sv
module pclk_gate_ctrl_test;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [N-1:0] clk_en_out;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int m_en [N];
  int m_code [N];
  int m_wait [N];
  int m_sel;
  logic [31:0] m_rd;

  always #10 clk = ~clk;

  pclk_gate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .clk_en_out(clk_en_out)
  );

  function automatic logic [31:0] status_word(int id);
    int e, c;
    e = (id < 2) ? 1 : m_en[id];
    c = (id < 2) ? 0 : m_code[id];
    return 32'(e * (1 << 28) + c * 65536 + id);
  endfunction

  function automatic logic [N-1:0] expected_out();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (i < 2) ? 1'b1 : (m_en[i] != 0 && m_wait[i] == 0);
    return v;
  endfunction

  task automatic step(input bit w, input logic [31:0] wd, input bit r, input string tag);
    logic [N-1:0] exp_v;
    int id, ncode, nen;
    @(negedge clk);
    wr_en = w; wr_data = wd; rd_en = r;
    #2;
    exp_v = expected_out();
    vectors++;
    if (clk_en_out !== exp_v) begin
      fails++;
      $display("FAIL %s clk_en_out got %h expected %h at %0t", tag, clk_en_out, exp_v, $time);
    end
    if (rd_data !== m_rd) begin
      fails++;
      $display("FAIL %s rd_data got %h expected %h at %0t", tag, rd_data, m_rd, $time);
    end
    @(posedge clk);
    for (int i = 2; i < N; i++) begin
      if (m_en[i] != 0) begin
        if (m_wait[i] == 0) m_wait[i] = (1 << m_code[i]) - 1;
        else m_wait[i] = m_wait[i] - 1;
      end
    end
    if (r) m_rd = status_word(m_sel);
    if (w) begin
      id = int'(wd[5:0]);
      m_sel = id;
      if (wd[12] && id >= 2) begin
        ncode = int'(wd[17:16]);
        nen = int'(wd[28]);
        if (nen != 0 && m_en[id] == 0) m_wait[id] = (1 << ncode) - 1;
        m_en[id] = nen;
        m_code[id] = ncode;
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 32'h0, 0, tag);
  endtask

  function automatic logic [31:0] cmd(int id, int code, int en);
    return 32'(en * (1 << 28) + code * 65536 + 4096 + id);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_code[i] = 0; m_wait[i] = 0; end
    m_sel = 0; m_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R5: reset state, then read the reset selection (peripheral 0)
    idle(2, "R5");
    step(0, 0, 1, "R5");
    idle(1, "R5");

    // R1: select-only write carrying enable and code bits has no effect
    step(1, 32'h1003_0009, 0, "R1");
    step(0, 0, 1, "R1");
    idle(3, "R1");

    // R2 / R6: enable peripheral 9 at code 0, 7 at code 2, 63 at code 3
    step(1, cmd(9, 0, 1), 0, "R2");
    idle(4, "R6");
    step(1, cmd(7, 2, 1), 0, "R6");
    step(1, cmd(63, 3, 1), 0, "R6");
    step(0, 0, 1, "R2");
    idle(20, "R6");

    // R8: mid-period code changes, faster then slower
    idle(1, "R8");
    step(1, cmd(7, 1, 1), 0, "R8");
    idle(3, "R8");
    step(1, cmd(63, 0, 1), 0, "R8");
    idle(10, "R8");
    step(1, cmd(63, 2, 1), 0, "R8");
    idle(12, "R8");

    // R7: disable peripheral 9 and read it back
    step(1, cmd(9, 1, 0), 0, "R7");
    idle(3, "R7");
    step(0, 0, 1, "R7");
    idle(2, "R7");

    // R4: attempts to reconfigure the pinned slots
    step(1, cmd(0, 3, 0), 0, "R4");
    step(0, 0, 1, "R4");
    idle(1, "R4");
    step(1, cmd(1, 2, 0), 1, "R4");
    step(0, 0, 1, "R4");
    idle(2, "R4");

    // R3: read and write in the same cycle reports the earlier selection
    step(1, cmd(7, 3, 1), 1, "R3");
    step(0, 0, 1, "R3");
    idle(2, "R3");

    // R6: mixed traffic, compared every clock
    seed = 32'h1234;
    for (int k = 0; k < 600; k++) begin
      logic [31:0] wd;
      bit w, r;
      seed = seed * 1103515245 + 12345;
      w = (seed[17:16] == 2'b00);
      r = seed[20];
      wd = {3'b0, seed[22], 10'b0, seed[24:23], 3'b0, seed[25], 6'b0, seed[31:26]};
      step(w, wd, r, "R6");
    end
    idle(10, "R6");
    finish_run();
  end
endmodule